// File: doc/BRIEF.md
# Sample-Rate Divider and Frame Generator

This block turns one of several timing sources into the audio sample rate. All logic runs on a single system clock. Each candidate source enters as a one-cycle tick enable: the incoming serial bit clock, two fixed-frequency oscillators, and an external clock. A source-select code picks one of these. A 3-bit rate code then sets how many ticks of that source make up one sample period. At the end of each period the block raises a one-cycle sample strobe.

When the block is bus master, it also produces the serial bit clock and a frame-sync pulse. It fits 64, 128 or 256 bit slots into every sample period. A phase accumulator spreads the slots evenly, so a frame always spans exactly one sample period, even when the divide factor is not a multiple of the frame length.

The configuration inputs are copied into an internal shadow set only at a sample boundary. They are also copied whenever the block is stopped. A running frame therefore always completes under the settings it started with. External sources must first pass a warm-up count before any strobe is issued. Unsupported combinations raise an error output and hold the block quiet.

Top module: `sfg_top`

## Requirements
- R1: For sources 1, 2 and 4, one sample period is a number of source ticks set by the rate code: 0→3072, 1→1536, 2→896, 3→768, 4→448, 5→384, 6→512, 7→2560.
- R2: Source code 0 (incoming bit clock, tick on `bclk_tick_i`) and source code 3 (external clock at 256× the sample rate, tick on `ext_tick_i`) use a fixed period of 256 ticks and ignore the rate code. Source 1 ticks on `osc_a_tick_i`, source 2 on `osc_b_tick_i`, and source 4 on `ext_tick_i`.
- R3: `sample_stb_o` is high for exactly one system cycle per sample period.
- R4: As master, `sclk_o` has exactly one rising edge per bit slot. There are exactly frame-length rising edges per sample period, and the frame restarts in step with the sample strobe.
- R5: As master, `fsync_o` rises once per frame, at the start of slot 0, with `sclk_o` high. It stays high for exactly ceil(period/frame length) source ticks.
- R6: Frame code 0 selects 64 slots, code 1 selects 128 and code 2 selects 256. Code 3 is reserved and raises `cfg_err_o`.
- R7: With source 0, the block acts as slave whatever `master_i` says: both output enables stay low. The frame is forced to 256 slots, so a reserved frame code causes no error.
- R8: In slave mode (`master_i`=0), `sclk_oe_o` and `fsync_oe_o` are low, and `sclk_o` and `fsync_o` stay low.
- R9: After an external source (code 3 or 4) is selected from a non-external one, `clk_ok_o` stays low until 2000 ticks of that source have arrived. No strobe is issued while it is low. Moving between codes 3 and 4 keeps `clk_ok_o` high.
- R10: `cfg_err_o` goes high, and no strobe is issued, in any of these cases: source 1 with rate code 4 or 5; source codes 5 to 7; or master mode with a period shorter than twice the frame length.
- R11: A configuration change made mid-frame takes effect at the next sample boundary. The frame in progress completes with the old period.
- R12: During and right after reset, `sample_stb_o`, `fsync_o`, both output enables and `cfg_err_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bclk_tick_i | input | 1 | One-cycle tick per incoming bit-clock period (source 0) |
| osc_a_tick_i | input | 1 | Tick per period of the first oscillator (source 1) |
| osc_b_tick_i | input | 1 | Tick per period of the second oscillator (source 2) |
| ext_tick_i | input | 1 | Tick per period of the external clock (sources 3 and 4) |
| src_sel_i | input | 3 | Clock-source code |
| rate_sel_i | input | 3 | Rate code selecting the divide factor |
| frame_sel_i | input | 2 | Frame-size code |
| master_i | input | 1 | 1 = drive bit clock and frame sync |
| sample_stb_o | output | 1 | One-cycle sample strobe |
| sclk_o | output | 1 | Generated bit clock |
| sclk_oe_o | output | 1 | Output enable for the bit clock |
| fsync_o | output | 1 | Generated frame-sync pulse |
| fsync_oe_o | output | 1 | Output enable for the frame sync |
| clk_ok_o | output | 1 | Selected source is usable |
| cfg_err_o | output | 1 | Active configuration is unsupported |

## Verification
The bench measures each sample period in source ticks. It also counts bit-clock rising edges and frame-sync width per frame.

The 448-tick period against a 128-slot frame is the main corner case: a divider that assumed an integer slot length would drift and give the wrong edge count or a misplaced frame sync. A mid-frame rate change catches a design that applies new settings at once and cuts the running frame short.

Three more cases are exercised. The source-0 override, given a master flag and a reserved frame code, catches a design that drives the pins or flags an error. The external warm-up, fed with gapped ticks, catches a count of system cycles instead of source ticks. The forbidden rate/source pairs must stay silent rather than emit strobes.

// File: rtl/sfg_pkg.sv
// Package: shared widths, configuration record and the rate-code table
// for the sample-rate divider and frame generator.
package sfg_pkg;
    localparam int SRC_W   = 3;
    localparam int RATE_W  = 3;
    localparam int FSZ_W   = 2;
    localparam int FACT_W  = 12;   // holds the largest divide factor (3072)
    localparam int LEN_W   = 9;    // holds the largest frame length (256)
    localparam int SLOT_W  = 8;    // slot index 0..255

    localparam logic [SRC_W-1:0] SRC_BCLK    = 3'd0;
    localparam logic [SRC_W-1:0] SRC_OSC_A   = 3'd1;
    localparam logic [SRC_W-1:0] SRC_OSC_B   = 3'd2;
    localparam logic [SRC_W-1:0] SRC_EXT_FS  = 3'd3;
    localparam logic [SRC_W-1:0] SRC_EXT_DIV = 3'd4;

    localparam logic [FACT_W-1:0] FIXED_FACTOR = 12'd256;

    typedef struct packed {
        logic [SRC_W-1:0]  src;
        logic [RATE_W-1:0] rate;
        logic [FSZ_W-1:0]  fsz;
        logic              master;
    } cfg_t;

    // Divide factor in source ticks for each rate code.
    function automatic logic [FACT_W-1:0] rate_factor(input logic [RATE_W-1:0] code);
        case (code)
            3'd0:    return 12'd3072;
            3'd1:    return 12'd1536;
            3'd2:    return 12'd896;
            3'd3:    return 12'd768;
            3'd4:    return 12'd448;
            3'd5:    return 12'd384;
            3'd6:    return 12'd512;
            default: return 12'd2560;
        endcase
    endfunction
endpackage

// File: rtl/sfg_cfg.sv
// Module: sfg_cfg
// Holds the shadow copy of the configuration and resolves it into the
// effective divide factor, frame length, master flag and error flag.
// Assumes load_i is only raised at a sample boundary or while stopped.
module sfg_cfg
    import sfg_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_i,
    input  cfg_t              cfg_i,
    output logic [SRC_W-1:0]  src_o,
    output logic              primed_o,
    output logic [FACT_W-1:0] factor_o,
    output logic [LEN_W-1:0]  flen_o,
    output logic              master_o,
    output logic              err_o
);
    cfg_t shadow;
    logic primed;
    logic by_bclk;
    logic fixed_rate;
    logic [FACT_W:0] twice_len;
    logic rate_bad;

    // Capture the requested configuration when the block allows it.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shadow <= '0;
            primed <= 1'b0;
        end else if (load_i) begin
            shadow <= cfg_i;
            primed <= 1'b1;
        end
    end

    // Resolve overrides and the period length from the shadow copy.
    always_comb begin
        by_bclk    = (shadow.src == SRC_BCLK);
        fixed_rate = by_bclk || (shadow.src == SRC_EXT_FS);
        factor_o   = fixed_rate ? FIXED_FACTOR : rate_factor(shadow.rate);
        if (by_bclk) begin
            flen_o = 9'd256;
        end else begin
            case (shadow.fsz)
                2'd0:    flen_o = 9'd64;
                2'd1:    flen_o = 9'd128;
                default: flen_o = 9'd256;
            endcase
        end
        master_o = shadow.master && !by_bclk;
    end

    // Flag combinations the block cannot serve.
    always_comb begin
        twice_len = {{(FACT_W-LEN_W){1'b0}}, flen_o, 1'b0};
        rate_bad  = (shadow.src == SRC_OSC_A) &&
                    ((shadow.rate == 3'd4) || (shadow.rate == 3'd5));
        err_o = (shadow.src > SRC_EXT_DIV) || rate_bad ||
                (!by_bclk && (shadow.fsz == 2'd3)) ||
                (master_o && ({1'b0, factor_o} < twice_len));
    end

    assign src_o    = shadow.src;
    assign primed_o = primed;

    // A period shorter than one slot per tick pair never runs in master mode.
    p_slot_room_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (primed && master_o && !err_o) |-> ({1'b0, factor_o} >= {{(FACT_W-LEN_W){1'b0}}, flen_o, 1'b0}));
endmodule

// File: rtl/sfg_clkmon.sv
// Module: sfg_clkmon
// Selects the tick of the active clock source and gates external sources
// until a warm-up count of their ticks has been seen.
// Assumes ticks are single-cycle enables in the system clock domain.
module sfg_clkmon
    import sfg_pkg::*;
#(
    parameter int WARMUP = 2000
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [SRC_W-1:0] src_i,
    input  logic             bclk_tick_i,
    input  logic             osc_a_tick_i,
    input  logic             osc_b_tick_i,
    input  logic             ext_tick_i,
    output logic             tick_o,
    output logic             ok_o
);
    localparam int CNT_W = $clog2(WARMUP + 1);
    localparam logic [CNT_W-1:0] WARM_LAST = CNT_W'(WARMUP);

    logic             is_ext;
    logic             was_ext;
    logic [CNT_W-1:0] warm_cnt;

    // Route the tick of the selected source.
    always_comb begin
        case (src_i)
            SRC_BCLK:    tick_o = bclk_tick_i;
            SRC_OSC_A:   tick_o = osc_a_tick_i;
            SRC_OSC_B:   tick_o = osc_b_tick_i;
            SRC_EXT_FS:  tick_o = ext_tick_i;
            SRC_EXT_DIV: tick_o = ext_tick_i;
            default:     tick_o = 1'b0;
        endcase
    end

    assign is_ext = (src_i == SRC_EXT_FS) || (src_i == SRC_EXT_DIV);

    // Count external ticks since the external source was chosen.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            was_ext  <= 1'b0;
            warm_cnt <= '0;
        end else begin
            was_ext <= is_ext;
            if (!is_ext || !was_ext) begin
                warm_cnt <= '0;
            end else if (tick_o && (warm_cnt != WARM_LAST)) begin
                warm_cnt <= warm_cnt + 1'b1;
            end
        end
    end

    assign ok_o = !is_ext || (was_ext && (warm_cnt == WARM_LAST));

    p_warm_cap_r9: assert property (@(posedge clk) disable iff (!rst_n)
        warm_cnt <= WARM_LAST);
    p_warm_steps_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (is_ext && was_ext && $past(is_ext) && $past(was_ext)) |->
            ((warm_cnt == $past(warm_cnt)) || (warm_cnt == $past(warm_cnt) + 1'b1)));
endmodule

// File: rtl/sfg_div.sv
// Module: sfg_div
// Counts source ticks and marks the last tick of each sample period.
// Assumes factor_i only changes when the counter sits at zero.
module sfg_div
    import sfg_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run_i,
    input  logic              tick_i,
    input  logic [FACT_W-1:0] factor_i,
    output logic              wrap_o
);
    logic [FACT_W-1:0] cnt;
    logic              at_last;

    assign at_last = (cnt == factor_i - 1'b1);
    assign wrap_o  = run_i && tick_i && at_last;

    // Advance the period counter on every accepted tick.
    always_ff @(posedge clk) begin
        if (!rst_n || !run_i) begin
            cnt <= '0;
        end else if (tick_i) begin
            cnt <= at_last ? '0 : cnt + 1'b1;
        end
    end

    p_cnt_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
        cnt < factor_i);
    p_hold_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (run_i && !tick_i) |=> (cnt == $past(cnt)));
endmodule

// File: rtl/sfg_frame.sv
// Module: sfg_frame
// Spreads the frame's bit slots over one sample period with a phase
// accumulator and derives the bit clock and the frame-sync pulse.
// Assumes factor_i >= 2 * flen_i whenever master_i is set.
module sfg_frame
    import sfg_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run_i,
    input  logic              tick_i,
    input  logic              wrap_i,
    input  logic              master_i,
    input  logic [FACT_W-1:0] factor_i,
    input  logic [LEN_W-1:0]  flen_i,
    output logic              sclk_o,
    output logic              fsync_o
);
    logic [FACT_W-1:0] acc;
    logic [SLOT_W-1:0] slot;
    logic [FACT_W:0]   acc_sum;
    logic              slot_done;
    logic              last_slot;

    // Next phase and whether a slot boundary is crossed.
    always_comb begin
        acc_sum   = {1'b0, acc} + {{(FACT_W+1-LEN_W){1'b0}}, flen_i};
        slot_done = (acc_sum >= {1'b0, factor_i});
        last_slot = ({1'b0, slot} == flen_i - 1'b1);
    end

    // Step the phase accumulator and slot index per accepted tick.
    always_ff @(posedge clk) begin
        if (!rst_n || !run_i) begin
            acc  <= '0;
            slot <= '0;
        end else if (tick_i) begin
            if (slot_done) begin
                acc  <= FACT_W'(acc_sum - {1'b0, factor_i});
                slot <= last_slot ? '0 : slot + 1'b1;
            end else begin
                acc  <= acc_sum[FACT_W-1:0];
            end
        end
    end

    assign sclk_o  = master_i && run_i && (acc < (factor_i >> 1));
    assign fsync_o = master_i && run_i && (slot == '0);

    p_frame_aligned_r4: assert property (@(posedge clk) disable iff (!rst_n)
        wrap_i |=> ((acc == '0) && (slot == '0)));
    p_slot_range_r4: assert property (@(posedge clk) disable iff (!rst_n)
        {1'b0, slot} < flen_i);
    p_fsync_high_clk_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(fsync_o) |-> sclk_o);
endmodule

// File: rtl/sfg_top.sv
// Module: sfg_top
// Sample-rate divider and frame generator. Picks a tick source, divides it
// into sample periods and, as master, generates bit clock and frame sync.
// Configuration is taken at sample boundaries or whenever stopped.
module sfg_top
    import sfg_pkg::*;
#(
    parameter int WARMUP = 2000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bclk_tick_i,
    input  logic              osc_a_tick_i,
    input  logic              osc_b_tick_i,
    input  logic              ext_tick_i,
    input  logic [SRC_W-1:0]  src_sel_i,
    input  logic [RATE_W-1:0] rate_sel_i,
    input  logic [FSZ_W-1:0]  frame_sel_i,
    input  logic              master_i,
    output logic              sample_stb_o,
    output logic              sclk_o,
    output logic              sclk_oe_o,
    output logic              fsync_o,
    output logic              fsync_oe_o,
    output logic              clk_ok_o,
    output logic              cfg_err_o
);
    cfg_t              req_cfg;
    logic [SRC_W-1:0]  act_src;
    logic              primed;
    logic [FACT_W-1:0] factor;
    logic [LEN_W-1:0]  flen;
    logic              master_eff;
    logic              cfg_bad;
    logic              src_tick;
    logic              src_ok;
    logic              running;
    logic              wrap;
    logic              load;
    logic              stb_q;

    assign req_cfg = '{src: src_sel_i, rate: rate_sel_i, fsz: frame_sel_i, master: master_i};
    assign running = primed && src_ok && !cfg_bad;
    assign load    = !running || wrap;

    sfg_cfg u_cfg (
        .clk      (clk),
        .rst_n    (rst_n),
        .load_i   (load),
        .cfg_i    (req_cfg),
        .src_o    (act_src),
        .primed_o (primed),
        .factor_o (factor),
        .flen_o   (flen),
        .master_o (master_eff),
        .err_o    (cfg_bad)
    );

    sfg_clkmon #(.WARMUP(WARMUP)) u_clkmon (
        .clk          (clk),
        .rst_n        (rst_n),
        .src_i        (act_src),
        .bclk_tick_i  (bclk_tick_i),
        .osc_a_tick_i (osc_a_tick_i),
        .osc_b_tick_i (osc_b_tick_i),
        .ext_tick_i   (ext_tick_i),
        .tick_o       (src_tick),
        .ok_o         (src_ok)
    );

    sfg_div u_div (
        .clk      (clk),
        .rst_n    (rst_n),
        .run_i    (running),
        .tick_i   (src_tick),
        .factor_i (factor),
        .wrap_o   (wrap)
    );

    sfg_frame u_frame (
        .clk      (clk),
        .rst_n    (rst_n),
        .run_i    (running),
        .tick_i   (src_tick),
        .wrap_i   (wrap),
        .master_i (master_eff),
        .factor_i (factor),
        .flen_i   (flen),
        .sclk_o   (sclk_o),
        .fsync_o  (fsync_o)
    );

    // Register the end-of-period mark into the sample strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) stb_q <= 1'b0;
        else        stb_q <= wrap;
    end

    assign sample_stb_o = stb_q;
    assign sclk_oe_o    = primed && master_eff;
    assign fsync_oe_o   = primed && master_eff;
    assign clk_ok_o     = src_ok;
    assign cfg_err_o    = primed && cfg_bad;

    p_stb_single_r3: assert property (@(posedge clk) disable iff (!rst_n)
        sample_stb_o |=> !sample_stb_o);
    p_err_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_err_o |=> !sample_stb_o);
    p_warm_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !clk_ok_o |=> !sample_stb_o);
    p_slave_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !sclk_oe_o |-> (!sclk_o && !fsync_o));
endmodule

// File: tb/sfg_top_bench.sv
module sfg_top_bench;
    localparam int CLK_PERIOD = 10;

    typedef struct {
        int    ticks;
        int    rises;
        int    fsyncs;
        int    fwidth;
        string req;
    } exp_t;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bclk_tick_i = 1'b1;
    logic       osc_a_tick_i = 1'b1;
    logic       osc_b_tick_i = 1'b1;
    logic       ext_tick_i = 1'b1;
    logic [2:0] src_sel_i = 3'd1;
    logic [2:0] rate_sel_i = 3'd6;
    logic [1:0] frame_sel_i = 2'd0;
    logic       master_i = 1'b1;
    logic       sample_stb_o, sclk_o, sclk_oe_o, fsync_o, fsync_oe_o, clk_ok_o, cfg_err_o;

    int   total = 0;
    int   bad = 0;
    int   stb_seen = 0;
    int   act_src = 1;
    bit   ext_gap = 1'b0;
    exp_t q[$];

    sfg_top u_sfg_top (
        .clk(clk), .rst_n(rst_n),
        .bclk_tick_i(bclk_tick_i), .osc_a_tick_i(osc_a_tick_i),
        .osc_b_tick_i(osc_b_tick_i), .ext_tick_i(ext_tick_i),
        .src_sel_i(src_sel_i), .rate_sel_i(rate_sel_i),
        .frame_sel_i(frame_sel_i), .master_i(master_i),
        .sample_stb_o(sample_stb_o), .sclk_o(sclk_o), .sclk_oe_o(sclk_oe_o),
        .fsync_o(fsync_o), .fsync_oe_o(fsync_oe_o),
        .clk_ok_o(clk_ok_o), .cfg_err_o(cfg_err_o)
    );

    initial forever #(CLK_PERIOD/2) clk = ~clk;

    // External ticks: every cycle, or every second cycle when gapped.
    initial begin
        bit ph = 1'b0;
        forever begin
            @(posedge clk);
            #1;
            ph = !ph;
            ext_tick_i = ext_gap ? ph : 1'b1;
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic bit cur_tick();
        case (act_src)
            0:       return bclk_tick_i;
            1:       return osc_a_tick_i;
            2:       return osc_b_tick_i;
            default: return ext_tick_i;
        endcase
    endfunction

    // Monitor: measures each frame and compares it with the queued expectation.
    initial begin
        int  m_ticks = 0, m_rises = 0, m_fs = 0, m_fw = 0;
        bit  p_sclk = 1'b0, p_fs = 1'b0;
        forever begin
            int t, r, f, w;
            exp_t e;
            @(negedge clk);
            t = int'(cur_tick());
            r = int'(sclk_o && !p_sclk);
            f = int'(fsync_o && !p_fs);
            w = int'(fsync_o && cur_tick());
            p_sclk = sclk_o;
            p_fs = fsync_o;
            if (sample_stb_o) begin
                if (q.size() > 0) begin
                    e = q.pop_front();
                    chk(m_ticks == e.ticks, {e.req, " period ticks"}, m_ticks, e.ticks);
                    chk(m_rises == e.rises, {e.req, " sclk rises"}, m_rises, e.rises);
                    chk(m_fs == e.fsyncs, {e.req, " fsync pulses"}, m_fs, e.fsyncs);
                    chk(m_fw == e.fwidth, {e.req, " fsync width"}, m_fw, e.fwidth);
                end
                m_ticks = t; m_rises = r; m_fs = f; m_fw = w;
                stb_seen++;
            end else begin
                m_ticks += t; m_rises += r; m_fs += f; m_fw += w;
            end
        end
    end

    // Driver helpers.
    task automatic push(input int ticks, input int flen, input bit mst, input string req);
        exp_t e;
        e.ticks  = ticks;
        e.rises  = mst ? flen : 0;
        e.fsyncs = mst ? 1 : 0;
        e.fwidth = mst ? (ticks + flen - 1) / flen : 0;
        e.req    = req;
        q.push_back(e);
    endtask

    task automatic wait_stb(input int n);
        int n0 = stb_seen;
        for (int i = 0; i < 20000; i++) begin
            @(negedge clk);
            if (stb_seen >= n0 + n) return;
        end
        chk(1'b0, "R3 strobe timeout", stb_seen - n0, n);
    endtask

    task automatic wait_empty();
        for (int i = 0; i < 40000; i++) begin
            @(negedge clk);
            if (q.size() == 0) return;
        end
        chk(1'b0, "R3 frames missing", q.size(), 0);
        q.delete();
    endtask

    task automatic apply(input int s, input int r, input int f, input bit m);
        @(negedge clk);
        src_sel_i = 3'(s); rate_sel_i = 3'(r); frame_sel_i = 2'(f); master_i = m;
        act_src = s;
    endtask

    // Change configuration while running: away from a boundary, then resync.
    task automatic reconfig(input int s, input int r, input int f, input bit m);
        wait_stb(1);
        apply(s, r, f, m);
        wait_stb(1);
    endtask

    task automatic expect_silent(input string req);
        int n0 = stb_seen;
        repeat (2000) @(negedge clk);
        chk(cfg_err_o == 1'b1, {req, " error flag"}, int'(cfg_err_o), 1);
        chk(stb_seen == n0, {req, " no strobe"}, stb_seen - n0, 0);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        chk(1'b0, "watchdog expired", 0, 1);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        int factors[8] = '{3072, 1536, 896, 768, 448, 384, 512, 2560};
        repeat (4) @(negedge clk);
        // R12: reset state
        chk(!sample_stb_o, "R12 strobe in reset", int'(sample_stb_o), 0);
        chk(!sclk_oe_o && !fsync_oe_o, "R12 enables in reset", int'(sclk_oe_o), 0);
        chk(!fsync_o && !cfg_err_o, "R12 fsync/err in reset", int'(fsync_o), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!sample_stb_o, "R12 strobe after reset", int'(sample_stb_o), 0);

        // R1 R4 R5: source 1, 512-tick period, 64 slots, master
        wait_stb(1);
        chk(sclk_oe_o && fsync_oe_o, "R4 master enables", int'(sclk_oe_o), 1);
        push(512, 64, 1, "R1 R4 R5 src1/512/64");
        push(512, 64, 1, "R1 R4 R5 src1/512/64");
        wait_empty();

        // R1 R8: rate sweep on source 2 in slave mode
        for (int r = 0; r < 8; r++) begin
            reconfig(2, r, 0, 1'b0);
            chk(!sclk_oe_o && !fsync_oe_o, "R8 slave enables", int'(sclk_oe_o), 0);
            push(factors[r], 64, 1'b0, "R1 R8 rate sweep");
            wait_empty();
        end

        // R4 R5 R6: 448-tick period with 128 slots (not a multiple)
        reconfig(2, 4, 1, 1'b1);
        push(448, 128, 1, "R4 R5 R6 frac 448/128");
        push(448, 128, 1, "R4 R5 R6 frac 448/128");
        wait_empty();

        // R6: 256-slot frame on source 1
        reconfig(1, 1, 2, 1'b1);
        push(1536, 256, 1, "R6 src1/1536/256");
        wait_empty();

        // R11: change mid-frame, current frame keeps old period
        reconfig(2, 6, 0, 1'b1);
        wait_stb(1);
        push(512, 64, 1, "R11 old frame");
        push(384, 64, 1, "R11 new frame");
        repeat (100) @(negedge clk);
        rate_sel_i = 3'd5;
        wait_empty();

        // R10: unsupported combinations stay quiet
        wait_stb(1);
        apply(1, 4, 0, 1'b1);
        wait_stb(1);
        expect_silent("R10 src1 rate4");
        apply(1, 5, 0, 1'b0);
        expect_silent("R10 src1 rate5");
        apply(1, 6, 3, 1'b1);
        expect_silent("R6 reserved frame code");
        apply(2, 5, 2, 1'b1);
        expect_silent("R10 period below two ticks per slot");
        apply(6, 0, 0, 1'b0);
        expect_silent("R10 source code 6");

        // R2 R7: bit clock as source forces slave and 256 slots
        apply(0, 0, 3, 1'b1);
        repeat (3) @(negedge clk);
        chk(!cfg_err_o, "R7 reserved frame code overridden", int'(cfg_err_o), 0);
        chk(!sclk_oe_o && !fsync_oe_o, "R7 forced slave", int'(sclk_oe_o), 0);
        wait_stb(1);
        push(256, 256, 1'b0, "R2 R7 bclk period");
        wait_empty();

        // R9: warm-up of an external source with gapped ticks
        wait_stb(1);
        apply(5, 0, 0, 1'b0);
        wait_stb(1);
        repeat (4) @(negedge clk);
        ext_gap = 1'b1;
        apply(3, 0, 0, 1'b1);
        repeat (3000) @(negedge clk);
        chk(!clk_ok_o, "R9 clk_ok low at 1500 ticks", int'(clk_ok_o), 0);
        chk(!sample_stb_o, "R9 no strobe during warm-up", int'(sample_stb_o), 0);
        repeat (1200) @(negedge clk);
        chk(clk_ok_o, "R9 clk_ok high after 2000 ticks", int'(clk_ok_o), 1);
        wait_stb(1);
        push(256, 64, 1, "R2 R9 ext 256 gapped");
        push(256, 64, 1, "R2 R9 ext 256 gapped");
        wait_empty();

        // R1 R9: external divided source, no second warm-up
        reconfig(4, 6, 0, 1'b1);
        chk(clk_ok_o, "R9 clk_ok kept from 3 to 4", int'(clk_ok_o), 1);
        push(512, 64, 1, "R1 ext divided 512");
        wait_empty();

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule